// File: doc/BRIEF.md
# Double-Buffered Flash Page Cache

This block is the page-buffer datapath of a NAND-style memory. It has two page-sized stages. The cache stage faces the byte (or word) bus. The page-buffer stage exchanges whole pages with a small synchronous array model. A column pointer selects the cache location that the bus side writes or reads. Each write or read strobe moves the pointer forward by one location.

Whole-page transfers are started by single-cycle command pulses. A program copies the cache into the page buffer in one cycle and then commits the page buffer to the array, one word per cycle. The cache is free again at once, so the next page can be loaded while the previous one is written. A fetch fills the page buffer from the array. A separate transfer command then moves it into the cache. While the cache streams one page out, the next page can already be fetched. A copy-back commits whatever the page buffer holds to a new page address, with no new data.

Page geometry is set by parameters: word width, main-area words and spare-area words. For example, 8-bit words with 2048 + 64 locations give a full-size byte page, and 16-bit words with 1024 + 32 give the word-wide form. The defaults are small so that the array model stays compact.

Top module: `pcache_top`

## Requirements
- R1: After reset, `busy` is 0, the column pointer is 0 and every cache and page-buffer word reads as all ones.
- R2: A write strobe stores `busWrData` into the cache at the column pointer. A read strobe presents the cache word at the column pointer on `busRdData` during that cycle. Either strobe advances the pointer by one.
- R3: The pointer stops at PAGE_WORDS, which is the position just past the last spare-area word. At that position `busRdData` is all ones, writes are dropped and the pointer no longer moves.
- R4: `colLoadEn` loads the pointer from `colLoadVal`, and any value above PAGE_WORDS is clamped to PAGE_WORDS. In the same cycle, a read or write strobe has no effect.
- R5: An accepted program, copy-back or fetch holds `busy` high for exactly PAGE_WORDS cycles, starting with the cycle after the pulse.
- R6: A program copies the whole cache into the page buffer in the accept cycle and commits it to `pageAddr`. The cache can be written and read while that commit runs.
- R7: A fetch loads page `pageAddr` into the page buffer. The to-cache command then copies the page buffer into the cache and sets the pointer to 0.
- R8: While a fetch runs, the cache keeps the previously transferred page, and reads stream that page unchanged.
- R9: A copy-back commits the current page-buffer contents to `pageAddr` and leaves the cache untouched.
- R10: Any command pulse that arrives while `busy` is high is ignored.
- R11: A page that has never been committed is fetched as all ones, which is the erased state.
- R12: When several commands are pulsed in one cycle, only one is taken, in the order program, copy-back, fetch, to-cache.
- R13: A to-cache transfer overrides a bus strobe or pointer load in the same cycle: the strobe is dropped and the pointer ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe into the cache at the column pointer |
| busWrData | input | WORD_W | Word to write |
| busRdEn | input | 1 | Read strobe; advances the column pointer |
| busRdData | output | WORD_W | Cache word at the column pointer, all ones past the end |
| colLoadEn | input | 1 | Load the column pointer |
| colLoadVal | input | COL_W | New pointer value (clamped) |
| cmdProgram | input | 1 | Cache to page buffer, then commit |
| cmdCopyBack | input | 1 | Commit page buffer without reloading |
| cmdFetch | input | 1 | Array page into page buffer |
| cmdToCache | input | 1 | Page buffer into cache |
| pageAddr | input | PAGE_AW | Target page of the command |
| busy | output | 1 | Array operation in progress |

## Verification
The bound checker checks several properties on every cycle:
- the pointer never goes past PAGE_WORDS;
- all ones appear whenever the pointer sits at the end;
- a read strobe advances the pointer;
- no transfer strobe fires while busy;
- at most one operation strobe fires at a time;
- no busy run is longer than a page;
- the pointer returns to 0 after a to-cache copy.

Only the bench scenarios can show the data paths end to end: committed pages coming back intact, erased pages reading as ones, copy-back reusing buffered data, and refused or out-prioritised commands leaving the stored pages and the cache as they were.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic loadPbuf;   // cache -> page buffer, whole page in one cycle
    logic loadCache;  // page buffer -> cache, whole page in one cycle
    logic arrWrite;   // page buffer word opIdx -> array
    logic arrFetch;   // array word opIdx -> page buffer
  } pc_strobe_t;

  typedef enum logic [1:0] {
    PC_IDLE,
    PC_COMMIT,
    PC_FETCH
  } pc_state_t;

endpackage

// File: rtl/pcache_array.sv
module pcache_array #(
  parameter int WORD_W     = 8,
  parameter int PAGE_WORDS = 36,
  parameter int PAGES      = 8,
  localparam int IDX_W     = $clog2(PAGE_WORDS),
  localparam int PAGE_AW   = $clog2(PAGES),
  localparam int ARR_WORDS = PAGES * PAGE_WORDS,
  localparam int ARR_AW    = $clog2(ARR_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [PAGE_AW-1:0] page,
  input  logic [IDX_W-1:0]   idx,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_WORDS - 1);

  logic [WORD_W-1:0] store [ARR_WORDS];
  logic [PAGES-1:0]  written;
  logic [ARR_AW-1:0] addr;

  assign addr = ARR_AW'(page) * ARR_AW'(PAGE_WORDS) + ARR_AW'(idx);

  // Storage has no reset; pages not yet committed are masked by 'written'.
  always_ff @(posedge clk) begin
    if (wrEn) store[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) written <= '0;
    else if (wrEn && idx == LAST_IDX) written[page] <= 1'b1;
  end

  assign rdData = written[page] ? store[addr] : '1;

endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
  import pcache_pkg::*;
#(
  parameter int PAGE_WORDS = 36,
  parameter int PAGES      = 8,
  localparam int IDX_W     = $clog2(PAGE_WORDS),
  localparam int PAGE_AW   = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdProgram,
  input  logic               cmdCopyBack,
  input  logic               cmdFetch,
  input  logic               cmdToCache,
  input  logic [PAGE_AW-1:0] pageAddr,
  output pc_strobe_t         strb,
  output logic [IDX_W-1:0]   opIdx,
  output logic [PAGE_AW-1:0] opPage,
  output logic               busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_WORDS - 1);

  pc_state_t state;
  logic      startCommit;
  logic      startFetch;
  logic      lastWord;

  // Priority: program, copy-back, fetch, to-cache. Idle only.
  assign startCommit = (state == PC_IDLE) && (cmdProgram || cmdCopyBack);
  assign startFetch  = (state == PC_IDLE) && !cmdProgram && !cmdCopyBack && cmdFetch;
  assign lastWord    = (opIdx == LAST_IDX);

  always_comb begin
    strb = '0;
    unique case (state)
      PC_IDLE: begin
        strb.loadPbuf  = cmdProgram;
        strb.loadCache = !cmdProgram && !cmdCopyBack && !cmdFetch && cmdToCache;
      end
      PC_COMMIT: strb.arrWrite = 1'b1;
      PC_FETCH:  strb.arrFetch = 1'b1;
      default:   strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PC_IDLE;
      opIdx  <= '0;
      opPage <= '0;
    end else begin
      unique case (state)
        PC_IDLE: begin
          opIdx <= '0;
          if (startCommit) begin
            state  <= PC_COMMIT;
            opPage <= pageAddr;
          end else if (startFetch) begin
            state  <= PC_FETCH;
            opPage <= pageAddr;
          end
        end
        PC_COMMIT, PC_FETCH: begin
          if (lastWord) begin
            state <= PC_IDLE;
            opIdx <= '0;
          end else begin
            opIdx <= opIdx + 1'b1;
          end
        end
        default: state <= PC_IDLE;
      endcase
    end
  end

  assign busy = (state != PC_IDLE);

endmodule

// File: rtl/pcache_datapath.sv
module pcache_datapath
  import pcache_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int PAGE_WORDS = 36,
  parameter int PAGES      = 8,
  localparam int IDX_W     = $clog2(PAGE_WORDS),
  localparam int COL_W     = $clog2(PAGE_WORDS + 1),
  localparam int PAGE_AW   = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  pc_strobe_t         strb,
  input  logic [IDX_W-1:0]   opIdx,
  input  logic [PAGE_AW-1:0] opPage,
  input  logic               busWrEn,
  input  logic [WORD_W-1:0]  busWrData,
  input  logic               busRdEn,
  output logic [WORD_W-1:0]  busRdData,
  input  logic               colLoadEn,
  input  logic [COL_W-1:0]   colLoadVal,
  output logic [COL_W-1:0]   colPtr
);

  localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_WORDS);

  logic [WORD_W-1:0] cacheMem [PAGE_WORDS];
  logic [WORD_W-1:0] pbufMem  [PAGE_WORDS];
  logic [WORD_W-1:0] arrWord;
  logic [IDX_W-1:0]  colIdx;
  logic              colEnd;
  logic              busStep;
  logic              cacheWr;

  assign colEnd  = (colPtr == COL_END);
  assign colIdx  = colPtr[IDX_W-1:0];
  assign busStep = (busWrEn || busRdEn) && !colEnd && !colLoadEn && !strb.loadCache;
  assign cacheWr = busWrEn && !colEnd && !colLoadEn && !strb.loadCache;

  // Column pointer: to-cache > load > bus step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      colPtr <= '0;
    end else if (strb.loadCache) begin
      colPtr <= '0;
    end else if (colLoadEn) begin
      colPtr <= (colLoadVal > COL_END) ? COL_END : colLoadVal;
    end else if (busStep) begin
      colPtr <= colPtr + 1'b1;
    end
  end

  // Cache stage: bus side or whole-page copy from the page buffer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_WORDS; i++) cacheMem[i] <= '1;
    end else if (strb.loadCache) begin
      for (int i = 0; i < PAGE_WORDS; i++) cacheMem[i] <= pbufMem[i];
    end else if (cacheWr) begin
      cacheMem[colIdx] <= busWrData;
    end
  end

  // Page-buffer stage: whole-page copy from cache or word-wise fetch.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_WORDS; i++) pbufMem[i] <= '1;
    end else if (strb.loadPbuf) begin
      for (int i = 0; i < PAGE_WORDS; i++) pbufMem[i] <= cacheMem[i];
    end else if (strb.arrFetch) begin
      pbufMem[opIdx] <= arrWord;
    end
  end

  assign busRdData = colEnd ? '1 : cacheMem[colIdx];

  pcache_array #(
    .WORD_W    (WORD_W),
    .PAGE_WORDS(PAGE_WORDS),
    .PAGES     (PAGES)
  ) u_array (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (strb.arrWrite),
    .page  (opPage),
    .idx   (opIdx),
    .wrData(pbufMem[opIdx]),
    .rdData(arrWord)
  );

endmodule

// File: rtl/pcache_top.sv
module pcache_top
  import pcache_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int MAIN_WORDS  = 32,
  parameter int SPARE_WORDS = 4,
  parameter int PAGES       = 8,
  localparam int PAGE_WORDS = MAIN_WORDS + SPARE_WORDS,
  localparam int IDX_W      = $clog2(PAGE_WORDS),
  localparam int COL_W      = $clog2(PAGE_WORDS + 1),
  localparam int PAGE_AW    = $clog2(PAGES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [WORD_W-1:0]  busWrData,
  input  logic               busRdEn,
  output logic [WORD_W-1:0]  busRdData,
  input  logic               colLoadEn,
  input  logic [COL_W-1:0]   colLoadVal,
  input  logic               cmdProgram,
  input  logic               cmdCopyBack,
  input  logic               cmdFetch,
  input  logic               cmdToCache,
  input  logic [PAGE_AW-1:0] pageAddr,
  output logic               busy
);

  pc_strobe_t         strb;
  logic [IDX_W-1:0]   opIdx;
  logic [PAGE_AW-1:0] opPage;
  logic [COL_W-1:0]   colPtr;

  pcache_ctrl #(
    .PAGE_WORDS(PAGE_WORDS),
    .PAGES     (PAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdProgram (cmdProgram),
    .cmdCopyBack(cmdCopyBack),
    .cmdFetch   (cmdFetch),
    .cmdToCache (cmdToCache),
    .pageAddr   (pageAddr),
    .strb       (strb),
    .opIdx      (opIdx),
    .opPage     (opPage),
    .busy       (busy)
  );

  pcache_datapath #(
    .WORD_W    (WORD_W),
    .PAGE_WORDS(PAGE_WORDS),
    .PAGES     (PAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opIdx     (opIdx),
    .opPage    (opPage),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .busRdData (busRdData),
    .colLoadEn (colLoadEn),
    .colLoadVal(colLoadVal),
    .colPtr    (colPtr)
  );

endmodule

// File: rtl/pcache_checker.sv
module pcache_checker
  import pcache_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int PAGE_WORDS = 36,
  localparam int COL_W     = $clog2(PAGE_WORDS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              cmdProgram,
  input logic              cmdCopyBack,
  input logic              cmdFetch,
  input logic              busRdEn,
  input logic              colLoadEn,
  input logic [WORD_W-1:0] busRdData,
  input logic [COL_W-1:0]  colPtr,
  input pc_strobe_t        strb
);

  localparam logic [COL_W-1:0] COL_END = COL_W'(PAGE_WORDS);

  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  p_col_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    colPtr <= COL_END);

  p_end_reads_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (colPtr == COL_END) |-> (busRdData == '1));

  p_read_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !colLoadEn && !strb.loadCache && colPtr < COL_END)
      |=> (colPtr == $past(colPtr) + 1'b1));

  p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strb.loadPbuf && !strb.loadCache));

  p_one_op_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadPbuf, strb.loadCache, strb.arrWrite, strb.arrFetch}));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= PAGE_WORDS);

  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdProgram || cmdCopyBack || cmdFetch));

  p_tocache_col_r13: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCache |=> (colPtr == '0));

endmodule

bind pcache_top pcache_checker #(
  .WORD_W    (WORD_W),
  .PAGE_WORDS(PAGE_WORDS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .cmdProgram (cmdProgram),
  .cmdCopyBack(cmdCopyBack),
  .cmdFetch   (cmdFetch),
  .busRdEn    (busRdEn),
  .colLoadEn  (colLoadEn),
  .busRdData  (busRdData),
  .colPtr     (colPtr),
  .strb       (strb)
);

// File: tb/tb_pcache_top.sv
module tb_pcache_top;

  localparam int WORD_W     = 8;
  localparam int PAGE_WORDS = 36;
  localparam int COL_W      = $clog2(PAGE_WORDS + 1);
  localparam int PAGE_AW    = 3;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busWrEn = 1'b0;
  logic [WORD_W-1:0]  busWrData = '0;
  logic               busRdEn = 1'b0;
  logic [WORD_W-1:0]  busRdData;
  logic               colLoadEn = 1'b0;
  logic [COL_W-1:0]   colLoadVal = '0;
  logic               cmdProgram = 1'b0;
  logic               cmdCopyBack = 1'b0;
  logic               cmdFetch = 1'b0;
  logic               cmdToCache = 1'b0;
  logic [PAGE_AW-1:0] pageAddr = '0;
  logic               busy;

  int nChecks = 0;
  int nFails  = 0;
  int busyRun = 0;
  bit scoreRd = 1'b0;

  logic [WORD_W-1:0] expQ[$];
  string             tagQ[$];

  always #2 clk = ~clk;

  pcache_top dut (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .busRdEn    (busRdEn),
    .busRdData  (busRdData),
    .colLoadEn  (colLoadEn),
    .colLoadVal (colLoadVal),
    .cmdProgram (cmdProgram),
    .cmdCopyBack(cmdCopyBack),
    .cmdFetch   (cmdFetch),
    .cmdToCache (cmdToCache),
    .pageAddr   (pageAddr),
    .busy       (busy)
  );

  function automatic logic [7:0] patA(int i); return 8'(i) ^ 8'h5A; endfunction
  function automatic logic [7:0] patB(int i); return 8'(i * 3 + 1); endfunction
  function automatic logic [7:0] patC(int i); return 8'(8'hA0 + i); endfunction
  function automatic logic [7:0] patD(int i); return 8'(8'h81 + i * 5); endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: compares each scored read in mid-cycle.
  always @(negedge clk) begin
    if (scoreRd) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard empty", busRdData, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdData == e, t, busRdData, e);
      end
    end
  end

  // R5: every busy run lasts exactly one page of cycles.
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyRun++;
      else if (busyRun != 0) begin
        check(busyRun == PAGE_WORDS, "R5 busy length", busyRun, PAGE_WORDS);
        busyRun = 0;
      end
    end
  end

  task automatic busWrite(input logic [7:0] d);
    busWrEn = 1'b1;
    busWrData = d;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    busRdEn = 1'b1;
    scoreRd = 1'b1;
    tick();
    busRdEn = 1'b0;
    scoreRd = 1'b0;
  endtask

  task automatic setCol(input int v);
    colLoadEn = 1'b1;
    colLoadVal = COL_W'(v);
    tick();
    colLoadEn = 1'b0;
  endtask

  // kind: 0 program, 1 copy-back, 2 fetch, 3 to-cache
  task automatic doCmd(input int kind, input int pg);
    pageAddr = PAGE_AW'(pg);
    cmdProgram  = (kind == 0);
    cmdCopyBack = (kind == 1);
    cmdFetch    = (kind == 2);
    cmdToCache  = (kind == 3);
    tick();
    cmdProgram = 1'b0; cmdCopyBack = 1'b0; cmdFetch = 1'b0; cmdToCache = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    busRead(8'hFF, "R1 cache reset word");
    setCol(0);

    // R2 fill page A
    for (int i = 0; i < PAGE_WORDS; i++) busWrite(patA(i));
    busWrite(8'h00);                                 // R3 dropped at end
    setCol(35);
    busRead(patA(35), "R3 last spare word");
    busRead(8'hFF, "R3 past end ones");
    busRead(8'hFF, "R3 pointer saturated");
    setCol(0);
    for (int i = 0; i < 4; i++) busRead(patA(i), "R2 readback");

    // R4 clamp and load priority
    setCol(50);
    busRead(8'hFF, "R4 clamp to end");
    colLoadEn = 1'b1; colLoadVal = COL_W'(2); busRdEn = 1'b1;
    tick();
    colLoadEn = 1'b0; busRdEn = 1'b0;
    busRead(patA(2), "R4 load beats read strobe");

    // R6 program page 1 with A while reloading cache with B; R10 refusal
    doCmd(0, 1);
    setCol(0);
    for (int i = 0; i < 10; i++) busWrite(patB(i));
    check(busy == 1'b1, "R6 busy during overlap", busy, 1);
    doCmd(3, 0);                                     // R10 refused
    for (int i = 10; i < PAGE_WORDS; i++) busWrite(patB(i));
    waitIdle();
    setCol(0);
    for (int i = 0; i < PAGE_WORDS; i++) busRead(patB(i), "R6 R10 cache during commit");

    doCmd(0, 2);                                     // page 2 <- B
    waitIdle();

    // R7 fetch page 1, R8 fetch page 2 while streaming
    doCmd(2, 1);
    waitIdle();
    doCmd(3, 0);
    for (int i = 0; i < 18; i++) busRead(patA(i), "R7 fetched page");
    doCmd(2, 2);
    for (int i = 18; i < PAGE_WORDS; i++) busRead(patA(i), "R8 stream during fetch");
    waitIdle();
    doCmd(3, 0);
    for (int i = 0; i < PAGE_WORDS; i++) busRead(patB(i), "R7 second page");

    // R9 copy-back page buffer (B) to page 5
    setCol(0);
    for (int i = 0; i < 4; i++) busWrite(patC(i));
    doCmd(1, 5);
    waitIdle();
    setCol(0);
    for (int i = 0; i < 4; i++) busRead(patC(i), "R9 cache untouched");
    doCmd(2, 5);
    waitIdle();
    doCmd(3, 0);
    for (int i = 0; i < PAGE_WORDS; i++) busRead(patB(i), "R9 copied page");

    // R11 erased page, R10 program refused while fetching
    doCmd(2, 7);
    check(busy == 1'b1, "R10 busy after fetch", busy, 1);
    doCmd(0, 4);
    waitIdle();
    doCmd(3, 0);
    for (int i = 0; i < PAGE_WORDS; i++) busRead(8'hFF, "R11 erased page");
    doCmd(2, 4);
    waitIdle();
    doCmd(3, 0);
    for (int i = 0; i < 4; i++) busRead(8'hFF, "R10 refused program left page erased");

    // R13 to-cache beats bus write
    doCmd(2, 1);
    waitIdle();
    cmdToCache = 1'b1; busWrEn = 1'b1; busWrData = 8'h00;
    tick();
    cmdToCache = 1'b0; busWrEn = 1'b0;
    busRead(patA(0), "R13 pointer zero, write dropped");
    busRead(patA(1), "R13 next word");

    // R12 program beats fetch
    setCol(0);
    for (int i = 0; i < PAGE_WORDS; i++) busWrite(patD(i));
    pageAddr = PAGE_AW'(3); cmdProgram = 1'b1; cmdFetch = 1'b1;
    tick();
    cmdProgram = 1'b0; cmdFetch = 1'b0;
    waitIdle();
    doCmd(2, 3);
    waitIdle();
    doCmd(3, 0);
    for (int i = 0; i < PAGE_WORDS; i++) busRead(patD(i), "R12 program won");

    // R12 fetch beats to-cache
    setCol(0);
    busWrite(8'h11);
    pageAddr = PAGE_AW'(7); cmdFetch = 1'b1; cmdToCache = 1'b1;
    tick();
    cmdFetch = 1'b0; cmdToCache = 1'b0;
    waitIdle();
    setCol(0);
    busRead(8'h11, "R12 to-cache dropped");
    doCmd(3, 0);
    busRead(8'hFF, "R12 fetch taken");

    repeat (2) tick();
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule